// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block collects interrupt state for a bank of communication message buffers. Each buffer holds its own interrupt flag, interrupt enable and direction bit (receive or transmit). A per-buffer event pulse raises that buffer's flag, and software clears it by writing a one to it. From these per-buffer pairs the block derives two live summary flags, one for receive buffers and one for transmit buffers. These summaries are never stored, so software cannot clear them.

A global enable register gates eight interrupt lines. Six of the lines carry source flags that arrive as levels from outside: module, protocol, host interface, wakeup, receive FIFO A not-empty and receive FIFO B not-empty. The other two lines carry the receive and transmit summaries. Software reaches all of this through a simple word-wide register port. Reads are combinational and writes take effect at the clock edge.

Top module: `msgbuf_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, every buffer flag, buffer enable, buffer direction bit and global enable bit is 0, and all eight interrupt lines are low.
- R2: A one on bit n of `buf_evt` at a clock edge sets flag n. The flags read back at address 1, with buffer n at bit n.
- R3: A write to address 1 clears every flag whose data bit is 1 and leaves the flags under 0 bits unchanged.
- R4: If a buffer's event pulse and a clearing write for that buffer fall on the same edge, the flag ends up set.
- R5: Bit 9 of address 0 (receive summary) is 1 exactly when some buffer with direction 0 has both its flag and its enable set. Enables are at address 2 and directions at address 3, with buffer n at bit n.
- R6: Bit 8 of address 0 (transmit summary) is 1 exactly when some buffer with direction 1 has both its flag and its enable set.
- R7: Writes to bits 9 and 8 of address 0 have no effect. A summary falls once every contributing buffer has either its flag or its enable cleared.
- R8: Bits 7..0 of address 0 are the global enables, for the lines module(7), protocol(6), host interface(5), wakeup(4), FIFO B(3), FIFO A(2), receive buffer(1) and transmit buffer(0). `irq_lines[i]` is high only while source i is set and enable i is 1. `src_flags[5:0]` feed lines 7..2, in that order.
- R9: Summaries and lines follow the stored state combinationally. When the last contributing flag is cleared, the line falls in the same cycle that the flag reads 0.
- R10: Changing a buffer's direction bit moves its contribution from one summary to the other, so that it never counts toward both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 global, 1 flags, 2 enables, 3 directions) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| buf_evt | input | NUM_BUF | Per-buffer event pulses |
| src_flags | input | 6 | Level source flags for lines 7..2 |
| irq_lines | output | 8 | Gated interrupt lines |

## Verification
The summaries are tried with a mix of receive and transmit buffers. Contributions are removed in three separate ways: by clearing the flag, by dropping the enable and by flipping the direction. Each of these must be the one that changes the summary. The global gating is swept with a fixed source pattern under full, partial and zero enables, which separates a wrong bit order from a missing gate. A coincident event and clear at the same edge tests the set-wins priority, and a check that samples flag and line together tests same-cycle deassertion.

// File: rtl/msgbuf_irq_pkg.sv
// Shared constants for the message buffer interrupt aggregator.
// Assumes a 16-bit register port and at most 16 buffers.
package msgbuf_irq_pkg;
    localparam int REG_W      = 16;
    localparam int N_LINES    = 8;
    localparam int N_EXT_SRC  = 6;
    localparam int RX_SUM_BIT = 9;
    localparam int TX_SUM_BIT = 8;

    typedef enum logic [1:0] {
        SEL_GLOBAL = 2'd0,
        SEL_FLAG   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    localparam int LINE_TX = 0;
    localparam int LINE_RX = 1;
endpackage

// File: rtl/msgbuf_flag_bank.sv
// Per-buffer flag, enable and direction storage.
// Assumes: evt is a one-cycle pulse per buffer; clr_mask is only valid
// with clr_we. A set event beats a clear at the same edge.
module msgbuf_flag_bank #(
    parameter int NUM_BUF = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_BUF-1:0] clr_mask,
    input  logic               en_we,
    input  logic [NUM_BUF-1:0] en_wdata,
    input  logic               dir_we,
    input  logic [NUM_BUF-1:0] dir_wdata,
    output logic [NUM_BUF-1:0] flag_q,
    output logic [NUM_BUF-1:0] en_q,
    output logic [NUM_BUF-1:0] dir_q
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        logic clr_b;
        assign clr_b = clr_we & clr_mask[b];

        // Flag: set by event, write-one clear, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[b] <= 1'b0;
            else if (evt[b])   flag_q[b] <= 1'b1;
            else if (clr_b)    flag_q[b] <= 1'b0;
        end

        // Enable and direction: plain read/write bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[b]  <= 1'b0;
                dir_q[b] <= 1'b0;
            end else begin
                if (en_we)  en_q[b]  <= en_wdata[b];
                if (dir_we) dir_q[b] <= dir_wdata[b];
            end
        end
    end
endmodule

// File: rtl/msgbuf_summary.sv
// Live receive/transmit summary derivation from per-buffer state.
// Assumes direction 0 = receive, 1 = transmit. Purely combinational.
module msgbuf_summary #(
    parameter int NUM_BUF = 8
) (
    input  logic [NUM_BUF-1:0] flag,
    input  logic [NUM_BUF-1:0] en,
    input  logic [NUM_BUF-1:0] dir,
    output logic               rx_sum,
    output logic               tx_sum
);
    logic [NUM_BUF-1:0] active;

    // Reduce active pairs into the two direction classes.
    always_comb begin
        active = flag & en;
        rx_sum = |(active & ~dir);
        tx_sum = |(active & dir);
    end
endmodule

// File: rtl/msgbuf_line_gate.sv
// Global enable register and per-line gating of the eight interrupt lines.
// Assumes src is level-valid every cycle; outputs are combinational.
module msgbuf_line_gate
    import msgbuf_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_we,
    input  logic [N_LINES-1:0] gen_wdata,
    input  logic [N_LINES-1:0] src,
    output logic [N_LINES-1:0] gen_q,
    output logic [N_LINES-1:0] irq_lines
);
    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      gen_q <= '0;
        else if (gen_we) gen_q <= gen_wdata;
    end

    // Gate each source with its enable.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign irq_lines[i] = src[i] & gen_q[i];
    end
endmodule

// File: rtl/msgbuf_irq_agg.sv
// Top: register decode, per-buffer bank, summaries and line gating.
// Assumes 1 <= NUM_BUF <= 16; reads are combinational, writes at the edge.
module msgbuf_irq_agg
    import msgbuf_irq_pkg::*;
#(
    parameter int NUM_BUF = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_BUF-1:0] buf_evt,
    input  logic [N_EXT_SRC-1:0] src_flags,
    output logic [N_LINES-1:0] irq_lines
);
    reg_sel_e           sel;
    logic               we_glb, we_flag, we_en, we_dir;
    logic [NUM_BUF-1:0] buf_flag, buf_en, buf_dir;
    logic               rx_sum, tx_sum;
    logic [N_LINES-1:0] glb_en, line_src;
    logic               unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_addr);
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:N_LINES];

    // Decode write strobes per register.
    always_comb begin
        we_glb  = reg_wr && (sel == SEL_GLOBAL);
        we_flag = reg_wr && (sel == SEL_FLAG);
        we_en   = reg_wr && (sel == SEL_ENABLE);
        we_dir  = reg_wr && (sel == SEL_DIR);
    end

    msgbuf_flag_bank #(.NUM_BUF(NUM_BUF)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (buf_evt),
        .clr_we    (we_flag),
        .clr_mask  (reg_wdata[NUM_BUF-1:0]),
        .en_we     (we_en),
        .en_wdata  (reg_wdata[NUM_BUF-1:0]),
        .dir_we    (we_dir),
        .dir_wdata (reg_wdata[NUM_BUF-1:0]),
        .flag_q    (buf_flag),
        .en_q      (buf_en),
        .dir_q     (buf_dir)
    );

    msgbuf_summary #(.NUM_BUF(NUM_BUF)) u_sum (
        .flag   (buf_flag),
        .en     (buf_en),
        .dir    (buf_dir),
        .rx_sum (rx_sum),
        .tx_sum (tx_sum)
    );

    // Line sources: external levels on top, summaries at bits 1 and 0.
    always_comb begin
        line_src          = '0;
        line_src[N_LINES-1:2] = src_flags;
        line_src[LINE_RX] = rx_sum;
        line_src[LINE_TX] = tx_sum;
    end

    msgbuf_line_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_we    (we_glb),
        .gen_wdata (reg_wdata[N_LINES-1:0]),
        .src       (line_src),
        .gen_q     (glb_en),
        .irq_lines (irq_lines)
    );

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_GLOBAL: begin
                reg_rdata[N_LINES-1:0] = glb_en;
                reg_rdata[RX_SUM_BIT]  = rx_sum;
                reg_rdata[TX_SUM_BIT]  = tx_sum;
            end
            SEL_FLAG:   reg_rdata[NUM_BUF-1:0] = buf_flag;
            SEL_ENABLE: reg_rdata[NUM_BUF-1:0] = buf_en;
            SEL_DIR:    reg_rdata[NUM_BUF-1:0] = buf_dir;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msgbuf_irq_checker.sv
// Temporal checks on the aggregator, attached by bind below.
// Assumes the same NUM_BUF as the bound instance.
module msgbuf_irq_checker #(
    parameter int NUM_BUF = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [15:0]        reg_wdata,
    input logic [NUM_BUF-1:0] buf_evt,
    input logic [NUM_BUF-1:0] flag_q,
    input logic [NUM_BUF-1:0] en_q,
    input logic [NUM_BUF-1:0] dir_q,
    input logic [7:0]         glb_en,
    input logic               rx_sum,
    input logic               tx_sum,
    input logic [7:0]         irq_lines
);
    // R1: reset leaves all lines low at the next edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_lines == '0 && flag_q == '0 && glb_en == '0));

    // R2 and R4: any pulsed buffer is flagged after the edge, even under clear.
    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_evt != '0) |=> ((flag_q & $past(buf_evt)) == $past(buf_evt)));

    // R3: cleared bits without a coincident event read 0 after the edge.
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1)
        |=> ((flag_q & $past(reg_wdata[NUM_BUF-1:0] & ~buf_evt)) == '0));

    // R8: no line is high while its global enable is 0.
    assert_line_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines & ~glb_en) == '0);

    // R10: with no active transmit pair the transmit summary is low.
    assert_tx_only_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q & dir_q) == '0) |-> !tx_sum);

    // R5 and R7: with no active receive pair the receive summary is low.
    assert_rx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q & ~dir_q) == '0) |-> !rx_sum);
endmodule

bind msgbuf_irq_agg msgbuf_irq_checker #(.NUM_BUF(NUM_BUF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .buf_evt   (buf_evt),
    .flag_q    (buf_flag),
    .en_q      (buf_en),
    .dir_q     (buf_dir),
    .glb_en    (glb_en),
    .rx_sum    (rx_sum),
    .tx_sum    (tx_sum),
    .irq_lines (irq_lines)
);

// File: tb/msgbuf_irq_agg_bench.sv
`timescale 1ns/1ps
module msgbuf_irq_agg_bench;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NB-1:0] buf_evt = '0;
    logic [5:0]    src_flags = '0;
    logic [7:0]    irq_lines;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    msgbuf_irq_agg #(.NUM_BUF(NB)) u_msgbuf_irq_agg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_evt(buf_evt),
        .src_flags(src_flags), .irq_lines(irq_lines)
    );

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            item_t it;
            logic [15:0] act;
            wait (q.size() != 0);
            it = q.pop_front();
            act = it.is_irq ? {8'h00, irq_lines} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    // One edge of stimulus: optional write and event pulse, applied at negedge.
    task automatic step(input bit wr, input logic [1:0] a,
                        input logic [15:0] d, input logic [NB-1:0] e);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; buf_evt = e;
        @(negedge clk);
        reg_wr = 1'b0; buf_evt = '0; reg_wdata = '0;
    endtask

    // Driver: select a register and push its expected value.
    task automatic expect_rd(input logic [1:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        #1;
        q.push_back('{1'b0, exp, req});
        wait (q.size() == 0);
    endtask

    task automatic expect_irq(input logic [7:0] exp, input string req);
        #1;
        q.push_back('{1'b1, {8'h00, exp}, req});
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_rd(2'd0, 16'h0000, "R1 global");
        expect_rd(2'd1, 16'h0000, "R1 flags");
        expect_rd(2'd2, 16'h0000, "R1 enables");
        expect_rd(2'd3, 16'h0000, "R1 dirs");
        expect_irq(8'h00, "R1 lines");
        // R2: events set flags 0 and 2
        step(1'b0, 2'd0, 16'h0, 8'h05);
        expect_rd(2'd1, 16'h0005, "R2 flags set");
        step(1'b1, 2'd2, 16'h00FF, '0);
        step(1'b1, 2'd3, 16'h00F0, '0);
        // R5: receive summary with global gating off
        expect_rd(2'd0, 16'h0200, "R5 rx summary");
        expect_irq(8'h00, "R8 gated off");
        step(1'b1, 2'd0, 16'h0003, '0);
        expect_irq(8'h02, "R8 rx line");
        // R6: transmit buffer 4
        step(1'b0, 2'd0, 16'h0, 8'h10);
        expect_rd(2'd0, 16'h0303, "R6 tx summary");
        expect_irq(8'h03, "R6 tx line");
        // R7: writing summary bits has no effect
        step(1'b1, 2'd0, 16'h0300, '0);
        expect_rd(2'd0, 16'h0300, "R7 summary write ignored");
        step(1'b1, 2'd0, 16'h00FF, '0);
        // R8: line order with external sources
        src_flags = 6'b101010;
        expect_irq(8'hAB, "R8 all enabled");
        step(1'b1, 2'd0, 16'h000F, '0);
        expect_irq(8'h0B, "R8 partial enable");
        // R3: write-one clear
        step(1'b1, 2'd1, 16'h0001, '0);
        expect_rd(2'd1, 16'h0014, "R3 clear bit0");
        step(1'b1, 2'd1, 16'h0000, '0);
        expect_rd(2'd1, 16'h0014, "R3 zero write");
        // R7: summary drops by enable removal
        step(1'b1, 2'd2, 16'h00FB, '0);
        expect_rd(2'd0, 16'h010F, "R7 rx drop by enable");
        expect_irq(8'h09, "R7 lines after drop");
        // R4: set wins over clear
        step(1'b1, 2'd1, 16'h0010, 8'h10);
        expect_rd(2'd1, 16'h0014, "R4 set wins");
        // R10: move buffer 4 to receive
        step(1'b1, 2'd3, 16'h00E0, '0);
        expect_rd(2'd0, 16'h020F, "R10 direction move");
        expect_irq(8'h0A, "R10 lines");
        // R9: clearing last contributor drops line with the flag
        step(1'b1, 2'd1, 16'h0010, '0);
        expect_rd(2'd1, 16'h0004, "R9 flag cleared");
        expect_irq(8'h08, "R9 line same cycle");
        expect_rd(2'd0, 16'h000F, "R9 summary low");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule